// File: doc/BRIEF.md
# Programmable Polynomial LFSR Engine

This block runs bit-serial polynomial arithmetic, one bit per clock. It serves the inner loops of CRC generation, scrambling, whitening and hashing. The core is a 40-bit residue. On each active cycle the residue either shifts up by one place, or first has a 40-bit polynomial XORed into it and then shifts. A computed feedback bit enters at position 0.

Five runtime-programmable tap selectors each pick one residue bit. Per-signal gating masks build three signals as XORs of the first four taps and the current serial input bit:

- the feedback bit;
- the polynomial-XOR enable;
- the output bit.

The fifth tap can only be added into the output bit. Serial input is taken from an 8-bit input register. Output bits are collected in a 16-bit output register.

All state is reached through a byte-wide register port. Software loads the polynomial, residue, taps, masks and input byte, and then pulses start with a bit count of 1 to 16. The engine runs that many cycles, raises done and holds its state. The residue can be viewed in natural bit order or fully bit-reversed.

Top module: `lfsr_engine`

## Requirements
- R1: After reset every register reads 0, and busy_o and done_o are low.
- R2: Addresses 5..9 hold polynomial byte i = bits 8i+7..8i, and addresses 0..4 hold the residue bytes in the same way when the order bit is 0. Reads of addresses 22..31 return 0, and writes to them change nothing.
- R3: With the order bit (address 19, bit 0) set, residue byte i bit j maps to residue bit 39-(8i+j), for both reads and writes.
- R4: On an active cycle, residue bits 39..1 take bits 38..0 of the residue, XORed with the polynomial when the polynomial enable is 1. Bit 0 takes the feedback bit.
- R5: Tap selectors 1..5 (addresses 11..15, 6 bits each) pick residue bit n for an index n of 0..39. Indexes 40..63 yield 0.
- R6: The feedback, polynomial-enable and output masks are at addresses 16, 17 and 18. Mask bits 0..3 enable taps 1..4 and bit 4 enables the serial input bit. Each signal is the XOR of its enabled terms.
- R7: When address 19 bit 1 is set, tap 5 is XORed into the output bit.
- R8: Each active cycle consumes input register (address 10) bit 0 and shifts that register right with zero fill. The output register shifts left with the output bit entering at bit 0; its low byte is at address 20 and its high byte at address 21, read only.
- R9: Start with a count of 1..16 while idle sets busy at the next edge. Busy then lasts exactly count cycles, after which done is set and held until the next accepted start. Counts of 0 or above 16 are ignored.
- R10: While busy, register writes and start pulses are ignored.
- R11: Tap, mask and configuration registers read back their written values in 6, 5 and 2 bits respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| start_i | input | 1 | Start pulse |
| bit_cnt_i | input | 5 | Number of bits to process, 1..16 |
| busy_o | output | 1 | Engine running |
| done_o | output | 1 | Run finished, held until next start |

## Verification
Read data is combinational from the address, so a register value is due in the same cycle in which it is addressed. Write effects and start appear after one rising edge. A start with count N gives busy one edge later, N active edges, and done on edge N+1.

A behavioural model in the bench advances on the same rising edge as the design. All outputs, including one rotating read address per cycle, are compared at the following falling edge. That edge is half a period after every register update, so each comparison sees settled values.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int RES_W   = 40;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = RES_W / BYTE_W;
  localparam int TAP_W   = $clog2(RES_W);
  localparam int N_TAPS  = 5;
  localparam int N_TERMS = N_TAPS;          // taps 1..4 plus serial input
  localparam int N_GATES = 3;               // feedback, poly enable, output
  localparam int IN_W    = 8;
  localparam int OUT_W   = 16;
  localparam int CNT_W   = $clog2(OUT_W + 1);
  localparam int ADDR_W  = 5;

  localparam logic [ADDR_W-1:0] A_RES  = 5'd0;
  localparam logic [ADDR_W-1:0] A_POLY = 5'd5;
  localparam logic [ADDR_W-1:0] A_DIN  = 5'd10;
  localparam logic [ADDR_W-1:0] A_TAP  = 5'd11;
  localparam logic [ADDR_W-1:0] A_MASK = 5'd16;
  localparam logic [ADDR_W-1:0] A_CFG  = 5'd19;
  localparam logic [ADDR_W-1:0] A_OLO  = 5'd20;
  localparam logic [ADDR_W-1:0] A_OHI  = 5'd21;

  localparam int G_FB = 0;
  localparam int G_PE = 1;
  localparam int G_DO = 2;
endpackage

// File: rtl/lfsr_bit_order.sv
module lfsr_bit_order #(
  parameter int W = 40
) (
  input  logic         rev_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] flip;
  for (genvar i = 0; i < W; i++) begin : g_flip
    assign flip[i] = d_i[W-1-i];
  end
  assign q_o = rev_i ? flip : d_i;
endmodule

// File: rtl/lfsr_tap_mux.sv
module lfsr_tap_mux #(
  parameter int W     = 40,
  parameter int SEL_W = 6
) (
  input  logic [W-1:0]     d_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tap_o
);
  // out-of-range index yields 0
  always_comb begin
    tap_o = 1'b0;
    for (int i = 0; i < W; i++)
      if (sel_i == SEL_W'(i)) tap_o = d_i[i];
  end
endmodule

// File: rtl/lfsr_term_gate.sv
module lfsr_term_gate #(
  parameter int N = 5
) (
  input  logic [N-1:0] term_i,
  input  logic [N-1:0] mask_i,
  output logic         bit_o
);
  assign bit_o = ^(term_i & mask_i);
endmodule

// File: rtl/lfsr_engine.sv
module lfsr_engine
  import lfsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  output logic              busy_o,
  output logic              done_o
);
  logic [RES_W-1:0] res_q, poly_q, res_view, wr_view, res_from_wr, res_step;
  logic [IN_W-1:0]  din_q;
  logic [OUT_W-1:0] dataout_q;
  logic [N_TAPS-1:0][TAP_W-1:0]    tap_sel_q;
  logic [N_GATES-1:0][N_TERMS-1:0] mask_q;
  logic ml_out_q, fb5_en_q;
  logic [CNT_W-1:0] cnt_q;
  logic busy_q, done_q;
  logic [N_TAPS-1:0]  tap;
  logic [N_TERMS-1:0] terms;
  logic [N_GATES-1:0] gate;
  logic d0, poly_en, dout, start_ok;

  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    lfsr_tap_mux #(.W(RES_W), .SEL_W(TAP_W)) u_mux (
      .d_i(res_q), .sel_i(tap_sel_q[k]), .tap_o(tap[k]));
  end

  assign terms = {din_q[0], tap[N_TERMS-2:0]};

  for (genvar g = 0; g < N_GATES; g++) begin : g_gate
    lfsr_term_gate #(.N(N_TERMS)) u_gate (
      .term_i(terms), .mask_i(mask_q[g]), .bit_o(gate[g]));
  end

  assign d0       = gate[G_FB];
  assign poly_en  = gate[G_PE];
  assign dout     = gate[G_DO] ^ (fb5_en_q & tap[N_TAPS-1]);
  assign res_step = ((poly_en ? (res_q ^ poly_q) : res_q) << 1) | RES_W'(d0);

  // byte view of residue; reversal is its own inverse
  lfsr_bit_order #(.W(RES_W)) u_rd_view (.rev_i(ml_out_q), .d_i(res_q),   .q_o(res_view));
  lfsr_bit_order #(.W(RES_W)) u_wr_view (.rev_i(ml_out_q), .d_i(wr_view), .q_o(res_from_wr));

  always_comb begin
    wr_view = res_view;
    for (int b = 0; b < NBYTES; b++)
      if (wr_addr_i == A_RES + ADDR_W'(b)) wr_view[b*BYTE_W +: BYTE_W] = wr_data_i;
  end

  assign start_ok = start_i && !busy_q && (bit_cnt_i != '0) && (bit_cnt_i <= CNT_W'(OUT_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q     <= '0;
      poly_q    <= '0;
      din_q     <= '0;
      dataout_q <= '0;
      tap_sel_q <= '0;
      mask_q    <= '0;
      ml_out_q  <= 1'b0;
      fb5_en_q  <= 1'b0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else if (busy_q) begin
      res_q     <= res_step;
      din_q     <= din_q >> 1;
      dataout_q <= {dataout_q[OUT_W-2:0], dout};
      cnt_q     <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      if (wr_en_i) begin
        if (wr_addr_i < A_POLY) res_q <= res_from_wr;
        for (int b = 0; b < NBYTES; b++)
          if (wr_addr_i == A_POLY + ADDR_W'(b)) poly_q[b*BYTE_W +: BYTE_W] <= wr_data_i;
        if (wr_addr_i == A_DIN) din_q <= wr_data_i;
        for (int k = 0; k < N_TAPS; k++)
          if (wr_addr_i == A_TAP + ADDR_W'(k)) tap_sel_q[k] <= wr_data_i[TAP_W-1:0];
        for (int g = 0; g < N_GATES; g++)
          if (wr_addr_i == A_MASK + ADDR_W'(g)) mask_q[g] <= wr_data_i[N_TERMS-1:0];
        if (wr_addr_i == A_CFG) begin
          ml_out_q <= wr_data_i[0];
          fb5_en_q <= wr_data_i[1];
        end
      end
      if (start_ok) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cnt_q  <= bit_cnt_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (rd_addr_i == A_RES + ADDR_W'(b))  rd_data_o = res_view[b*BYTE_W +: BYTE_W];
      if (rd_addr_i == A_POLY + ADDR_W'(b)) rd_data_o = poly_q[b*BYTE_W +: BYTE_W];
    end
    for (int k = 0; k < N_TAPS; k++)
      if (rd_addr_i == A_TAP + ADDR_W'(k)) rd_data_o = 8'(tap_sel_q[k]);
    for (int g = 0; g < N_GATES; g++)
      if (rd_addr_i == A_MASK + ADDR_W'(g)) rd_data_o = 8'(mask_q[g]);
    if (rd_addr_i == A_DIN) rd_data_o = din_q;
    if (rd_addr_i == A_CFG) rd_data_o = {6'd0, fb5_en_q, ml_out_q};
    if (rd_addr_i == A_OLO) rd_data_o = dataout_q[7:0];
    if (rd_addr_i == A_OHI) rd_data_o = dataout_q[15:8];
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/lfsr_engine_chk.sv
module lfsr_engine_chk
  import lfsr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             done_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [RES_W-1:0] res_i,
  input logic [OUT_W-1:0] dout_reg_i,
  input logic             poly_en_i,
  input logic             wr_en_i
);
  assert_busy_done_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && done_i));

  assert_cnt_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (cnt_i != '0 && cnt_i <= CNT_W'(OUT_W)));

  assert_done_at_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $fell(busy_i));

  assert_plain_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !poly_en_i) |=> (res_i[RES_W-1:1] == $past(res_i[RES_W-2:0])));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !wr_en_i) |=> $stable(res_i));

  assert_out_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(dout_reg_i));
endmodule

bind lfsr_engine lfsr_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_q), .done_i(done_q),
  .cnt_i(cnt_q), .res_i(res_q), .dout_reg_i(dataout_q),
  .poly_en_i(poly_en), .wr_en_i(wr_en_i));

// File: tb/sim_lfsr_engine.sv
module sim_lfsr_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       wr_en = 1'b0, start = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0, bit_cnt = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       busy, done;
  int  total = 0, bad = 0;
  bit  hold_rd = 1'b0, finished = 1'b0;

  lfsr_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .start_i(start), .bit_cnt_i(bit_cnt), .busy_o(busy), .done_o(done));

  // behavioural reference
  logic [39:0] m_res, m_poly;
  logic [7:0]  m_din;
  logic [15:0] m_dout;
  int m_tap[5];
  int m_mask[3];
  bit m_ml, m_f5, m_busy, m_done;
  int m_cnt;

  function automatic logic [7:0] m_read(int a);
    logic [7:0] v = '0;
    if (a < 5) begin
      for (int j = 0; j < 8; j++) v[j] = m_ml ? m_res[39-(8*a+j)] : m_res[8*a+j];
    end else if (a < 10) v = m_poly[8*(a-5) +: 8];
    else if (a == 10) v = m_din;
    else if (a < 16) v = 8'(m_tap[a-11]);
    else if (a < 19) v = 8'(m_mask[a-16]);
    else if (a == 19) v = {6'd0, m_f5, m_ml};
    else if (a == 20) v = m_dout[7:0];
    else if (a == 21) v = m_dout[15:8];
    return v;
  endfunction

  function automatic string tag_of(int a);
    if (a < 5) return m_ml ? "R3" : "R2";
    if (a < 10) return "R2";
    if (a == 10 || a == 20 || a == 21) return "R8";
    if (a < 20) return "R11";
    return "R2";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_res = '0; m_poly = '0; m_din = '0; m_dout = '0;
      for (int k = 0; k < 5; k++) m_tap[k] = 0;
      for (int g = 0; g < 3; g++) m_mask[g] = 0;
      m_ml = 0; m_f5 = 0; m_busy = 0; m_done = 0; m_cnt = 0;
    end else if (m_busy) begin
      bit t[5];
      bit term[5];
      bit fb, pe, ob;
      logic [39:0] tmp;
      for (int k = 0; k < 5; k++) t[k] = (m_tap[k] < 40) ? m_res[m_tap[k]] : 1'b0;
      for (int k = 0; k < 4; k++) term[k] = t[k];
      term[4] = m_din[0];
      fb = 0; pe = 0; ob = 0;
      for (int k = 0; k < 5; k++) begin
        if (m_mask[0][k]) fb ^= term[k];
        if (m_mask[1][k]) pe ^= term[k];
        if (m_mask[2][k]) ob ^= term[k];
      end
      if (m_f5) ob ^= t[4];
      tmp = pe ? (m_res ^ m_poly) : m_res;
      m_res = {tmp[38:0], fb};
      m_din = {1'b0, m_din[7:1]};
      m_dout = {m_dout[14:0], ob};
      m_cnt--;
      if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
    end else begin
      if (wr_en) begin
        int a;
        a = int'(wr_addr);
        if (a < 5) begin
          for (int j = 0; j < 8; j++)
            if (m_ml) m_res[39-(8*a+j)] = wr_data[j]; else m_res[8*a+j] = wr_data[j];
        end else if (a < 10) m_poly[8*(a-5) +: 8] = wr_data;
        else if (a == 10) m_din = wr_data;
        else if (a < 16) m_tap[a-11] = int'(wr_data[5:0]);
        else if (a < 19) m_mask[a-16] = int'(wr_data[4:0]);
        else if (a == 19) begin m_ml = wr_data[0]; m_f5 = wr_data[1]; end
      end
      if (start && bit_cnt >= 1 && bit_cnt <= 16) begin
        m_busy = 1; m_done = 0; m_cnt = int'(bit_cnt);
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(8'(busy), 8'(m_busy), "R9 busy");
      chk(8'(done), 8'(m_done), "R9 done");
      if (!hold_rd) begin
        chk(rd_data, m_read(int'(rd_addr)), tag_of(int'(rd_addr)));
        rd_addr <= (rd_addr == 5'd23) ? 5'd0 : rd_addr + 5'd1;
      end
    end
  end

  // tasks are entered just after a falling edge
  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic go(input int n);
    start = 1; bit_cnt = 5'(n);
    @(negedge clk);
    start = 0;
    repeat (n + 3) @(negedge clk);
  endtask

  task automatic read_chk(input int a, input logic [7:0] exp, input string tag);
    @(posedge clk);
    #5;
    hold_rd = 1; rd_addr = 5'(a);
    #1;
    chk(rd_data, exp, tag);
    hold_rd = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 22; a++) read_chk(a, 8'h00, "R1");
    chk(8'(busy), 8'h00, "R1 busy");
    chk(8'(done), 8'h00, "R1 done");

    // R4 plain shift
    wr(0, 8'h01);
    go(5);
    read_chk(0, 8'h20, "R4");

    // R2 polynomial/residue bytes, unused address
    for (int b = 0; b < 5; b++) begin wr(5 + b, 8'h11 * (b + 1)); wr(b, 8'hA0 + b); end
    wr(25, 8'hFF);
    read_chk(25, 8'h00, "R2");
    read_chk(7, 8'h33, "R2");
    repeat (30) @(negedge clk);

    // R3 reversed view
    for (int b = 0; b < 5; b++) wr(b, 0);
    wr(19, 8'h01);
    wr(0, 8'h01);
    wr(19, 8'h00);
    read_chk(4, 8'h80, "R3");
    wr(19, 8'h01);
    repeat (30) @(negedge clk);
    wr(19, 8'h00);

    // R8 serial input straight to output
    wr(18, 8'h10);
    wr(10, 8'hB4);
    go(8);
    read_chk(20, 8'h2D, "R8");
    read_chk(10, 8'h00, "R8");

    // R5 out-of-range tap
    for (int b = 0; b < 5; b++) wr(b, 8'hFF);
    wr(11, 45); wr(16, 8'h01); wr(17, 8'h00); wr(18, 8'h00);
    go(3);
    read_chk(0, 8'hF8, "R5");

    // R6 CRC-like configuration
    for (int b = 0; b < 5; b++) begin wr(5 + b, 8'h07 + 8'h31 * b); wr(b, 8'h5A ^ b); end
    wr(11, 39); wr(12, 7); wr(13, 20); wr(14, 0);
    wr(16, 8'h11); wr(17, 8'h13); wr(18, 8'h0E);
    wr(10, 8'hA5);
    go(8);
    wr(10, 8'h3C);
    wr(17, 8'h1F);
    go(16);
    repeat (24) @(negedge clk);

    // R7 fifth tap to output
    wr(15, 2); wr(19, 8'h02);
    go(12);
    wr(19, 8'h03);
    go(9);
    repeat (24) @(negedge clk);

    // R10 writes and start ignored while busy
    wr(10, 8'hC3);
    start = 1; bit_cnt = 5'd10;
    @(negedge clk);
    start = 0;
    wr(0, 8'h00); wr(16, 8'h00);
    start = 1; bit_cnt = 5'd2;
    @(negedge clk);
    start = 0;
    repeat (12) @(negedge clk);
    read_chk(16, 8'h11, "R10");

    // R9 invalid counts, done held
    start = 1; bit_cnt = 5'd0; @(negedge clk);
    bit_cnt = 5'd17; @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    chk(8'(done), 8'h01, "R9 held");
    go(1);
    go(16);
    repeat (24) @(negedge clk);

    finish_run();
  end
endmodule